// File: doc/BRIEF.md
# Segmented ternary adder chain

This block is one slice of a cascadable arithmetic chain. It is built from ten two-bit cells, giving a 20-bit word. It adds either two operands (A + B) or three operands (A + B + C). In three-operand mode every bit position first reduces its three operand bits to a sum bit (XOR) and a majority bit. The majority bits travel one position up on a dedicated shared chain. The ordinary ripple carry then adds the sum bits to the shifted majority bits. Each two-bit cell resolves its carry by carry select: it evaluates both possible carry-in values and lets the arriving carry pick the result.

A segment select lets the chain use the whole slice, only the lower five cells, or only the upper five cells. The unused half is left idle and its sum bits read zero. The chain ports are carry in / carry out and shared in / shared out, and they connect combinationally, so identical slices can be stacked. When they are stacked, the lower half of one slice feeds the lower half of the next and the upper half feeds the upper half. The sum and a copy of the final carry are registered once; the raw carry is also given as an ordinary output.

Top module: `tern_chain_adder`

## Requirements
- R1: With seg_i = 2'b00 and three_op_i = 0, sum_q_o equals (A + B + carry_in_i) mod 2^20 one clock after the inputs are applied. carry_out_o is bit 20 of that total and is combinational.
- R2: With seg_i = 2'b00 and three_op_i = 1, the relation sum + 2^20 * (carry_out_o + shared_out_o) = A + B + C + carry_in_i + shared_in_i holds, with the sum appearing on sum_q_o one clock later.
- R3: With three_op_i = 0, c_i and shared_in_i have no effect on any output, and shared_out_o is 0.
- R4: With seg_i = 2'b01 only cells 0..4 (bits 9:0) are active. sum_q_o[9:0] is the sum of the operand bits 9:0 plus the chain inputs, carry_out_o is the carry out of bit 9, sum_q_o[19:10] is zero and operand bits 19:10 are ignored.
- R5: With seg_i = 2'b10 only cells 5..9 (bits 19:10) are active. The chain starts at cell 5 and takes carry_in_i and shared_in_i there. sum_q_o[9:0] is zero and operand bits 9:0 are ignored.
- R6: seg_i = 2'b11 behaves exactly like seg_i = 2'b00.
- R7: cout_reg_o equals the value carry_out_o had one clock earlier.
- R8: While rst is high, sum_q_o and cout_reg_o are zero after every clock edge.
- R9: Two slices joined as carry_out_o to carry_in_i and shared_out_o to shared_in_i form one adder of twice the active segment width, for every segment and both modes.
- R10: In three-operand mode shared_out_o is the majority of A, B and C at the top bit of the active segment: bit 19 for the full or upper segment, bit 9 for the lower segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 20 | Operand A |
| b_i | input | 20 | Operand B |
| c_i | input | 20 | Operand C (three-operand mode only) |
| three_op_i | input | 1 | 1 = add three operands, 0 = add two |
| seg_i | input | 2 | Segment: 00 full, 01 lower half, 10 upper half, 11 full |
| carry_in_i | input | 1 | Ripple carry into the first active cell |
| shared_in_i | input | 1 | Shared chain into the first active bit |
| sum_q_o | output | 20 | Registered sum |
| carry_out_o | output | 1 | Combinational carry from the last active cell |
| cout_reg_o | output | 1 | Registered copy of carry_out_o |
| shared_out_o | output | 1 | Combinational shared-chain output |

## Verification
Some properties are checked on every cycle. The idle half of the sum reads zero one clock after a half segment is selected. The shared output stays low in two-operand mode and implies a majority at the segment's top bit in three-operand mode. The registered carry follows the raw carry by one clock. The arithmetic itself can only be shown by the bench's scenarios. These are the carries that ripple the whole width, the operands ignored outside the segment, the alternate full encoding, and the 40-bit result of two stacked slices. The bench compares all of them against integer sums on every clock.

// File: rtl/tadd_pkg.sv
package tadd_pkg;

    localparam int unsigned CELL_W = 2;

    typedef enum logic [1:0] {
        SEG_FULL     = 2'b00,
        SEG_LOW      = 2'b01,
        SEG_HIGH     = 2'b10,
        SEG_FULL_ALT = 2'b11
    } seg_e;

    typedef struct packed {
        logic lo_on;
        logic hi_on;
    } seg_span_t;

    typedef struct packed {
        logic       co;
        logic [1:0] s;
    } cell_res_t;

    function automatic seg_span_t decode_seg(input seg_e sel);
        seg_span_t sp;
        case (sel)
            SEG_LOW:  begin sp.lo_on = 1'b1; sp.hi_on = 1'b0; end
            SEG_HIGH: begin sp.lo_on = 1'b0; sp.hi_on = 1'b1; end
            default:  begin sp.lo_on = 1'b1; sp.hi_on = 1'b1; end
        endcase
        return sp;
    endfunction

    function automatic cell_res_t add_pair(input logic [1:0] x, input logic [1:0] y,
                                           input logic ci);
        logic [2:0] t;
        t = {1'b0, x} + {1'b0, y} + {2'b00, ci};
        return cell_res_t'(t);
    endfunction

endpackage

// File: rtl/tadd_operand_stage.sv
module tadd_operand_stage
    import tadd_pkg::*;
#(
    parameter int unsigned W    = 20,
    parameter int unsigned HW   = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         three_op,
    input  seg_span_t    span,
    input  logic         shared_in,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         shared_out
);

    logic [W-1:0] xor3;
    logic [W-1:0] maj3;
    logic [W-1:0] shift_in;
    logic [W-1:0] active;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign xor3[i] = a[i] ^ b[i] ^ c[i];
            assign maj3[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);

            if (i < HW) begin : g_lo
                assign active[i] = span.lo_on;
            end else begin : g_hi
                assign active[i] = span.hi_on;
            end

            if (i == 0) begin : g_start0
                assign shift_in[i] = shared_in;
            end else if (i == HW) begin : g_start_mid
                assign shift_in[i] = (span.hi_on && !span.lo_on) ? shared_in : maj3[i-1];
            end else begin : g_mid
                assign shift_in[i] = maj3[i-1];
            end

            always_comb begin
                if (!active[i]) begin
                    x[i] = 1'b0;
                    y[i] = 1'b0;
                end else if (three_op) begin
                    x[i] = xor3[i];
                    y[i] = shift_in[i];
                end else begin
                    x[i] = a[i];
                    y[i] = b[i];
                end
            end
        end
    endgenerate

    always_comb begin
        if (!three_op)
            shared_out = 1'b0;
        else if (span.hi_on)
            shared_out = maj3[W-1];
        else
            shared_out = maj3[HW-1];
    end

endmodule

// File: rtl/tadd_cell.sv
module tadd_cell
    import tadd_pkg::*;
(
    input  logic [1:0] x,
    input  logic [1:0] y,
    input  logic       ci,
    output logic [1:0] s,
    output logic       co
);

    cell_res_t res_c0;
    cell_res_t res_c1;

    // both carry outcomes evaluated ahead of the arriving carry
    assign res_c0 = add_pair(x, y, 1'b0);
    assign res_c1 = add_pair(x, y, 1'b1);

    always_comb begin
        if (ci) begin
            s  = res_c1.s;
            co = res_c1.co;
        end else begin
            s  = res_c0.s;
            co = res_c0.co;
        end
    end

endmodule

// File: rtl/tadd_seg_chain.sv
module tadd_seg_chain
    import tadd_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 10
) (
    input  logic [NUM_CELLS*CELL_W-1:0] x,
    input  logic [NUM_CELLS*CELL_W-1:0] y,
    input  logic                        carry_in,
    input  seg_span_t                   span,
    output logic [NUM_CELLS*CELL_W-1:0] sum,
    output logic                        carry_out
);

    localparam int unsigned HALF = NUM_CELLS / 2;

    logic [NUM_CELLS:1]     c;
    logic [NUM_CELLS-1:0]   cell_ci;

    genvar k;
    generate
        for (k = 0; k < NUM_CELLS; k++) begin : g_cell
            if (k == 0) begin : g_first
                assign cell_ci[k] = span.lo_on ? carry_in : 1'b0;
            end else if (k == HALF) begin : g_mid
                always_comb begin
                    if (!span.lo_on)
                        cell_ci[k] = carry_in;
                    else if (span.hi_on)
                        cell_ci[k] = c[k];
                    else
                        cell_ci[k] = 1'b0;
                end
            end else begin : g_rip
                assign cell_ci[k] = c[k];
            end

            tadd_cell u_cell (
                .x  (x[k*CELL_W +: CELL_W]),
                .y  (y[k*CELL_W +: CELL_W]),
                .ci (cell_ci[k]),
                .s  (sum[k*CELL_W +: CELL_W]),
                .co (c[k+1])
            );
        end
    endgenerate

    assign carry_out = span.hi_on ? c[NUM_CELLS] : c[HALF];

endmodule

// File: rtl/tern_chain_adder.sv
module tern_chain_adder
    import tadd_pkg::*;
#(
    parameter int unsigned NUM_CELLS = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CELLS*CELL_W-1:0] a_i,
    input  logic [NUM_CELLS*CELL_W-1:0] b_i,
    input  logic [NUM_CELLS*CELL_W-1:0] c_i,
    input  logic                        three_op_i,
    input  logic [1:0]                  seg_i,
    input  logic                        carry_in_i,
    input  logic                        shared_in_i,
    output logic [NUM_CELLS*CELL_W-1:0] sum_q_o,
    output logic                        carry_out_o,
    output logic                        cout_reg_o,
    output logic                        shared_out_o
);

    localparam int unsigned W  = NUM_CELLS * CELL_W;
    localparam int unsigned HW = (NUM_CELLS / 2) * CELL_W;

    seg_span_t      span;
    logic [W-1:0]   x_w;
    logic [W-1:0]   y_w;
    logic [W-1:0]   sum_w;
    logic           carry_w;

    assign span = decode_seg(seg_e'(seg_i));

    tadd_operand_stage #(.W(W), .HW(HW)) u_ops (
        .a          (a_i),
        .b          (b_i),
        .c          (c_i),
        .three_op   (three_op_i),
        .span       (span),
        .shared_in  (shared_in_i),
        .x          (x_w),
        .y          (y_w),
        .shared_out (shared_out_o)
    );

    tadd_seg_chain #(.NUM_CELLS(NUM_CELLS)) u_chain (
        .x         (x_w),
        .y         (y_w),
        .carry_in  (carry_in_i),
        .span      (span),
        .sum       (sum_w),
        .carry_out (carry_w)
    );

    assign carry_out_o = carry_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q_o    <= '0;
            cout_reg_o <= 1'b0;
        end else begin
            sum_q_o    <= sum_w;
            cout_reg_o <= carry_w;
        end
    end

    logic [2:0] top_trio;
    always_comb begin
        if (span.hi_on)
            top_trio = {a_i[W-1], b_i[W-1], c_i[W-1]};
        else
            top_trio = {a_i[HW-1], b_i[HW-1], c_i[HW-1]};
    end

    // R4
    low_upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_i == 2'b01) |=> (sum_q_o[W-1:HW] == '0));

    // R5
    high_lower_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_i == 2'b10) |=> (sum_q_o[HW-1:0] == '0));

    // R3
    two_op_no_share_chk: assert property (@(posedge clk) disable iff (rst)
        !three_op_i |-> !shared_out_o);

    // R10
    share_majority_chk: assert property (@(posedge clk) disable iff (rst)
        (three_op_i && shared_out_o) |-> ($countones(top_trio) >= 2));

    // R7
    cout_reg_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cout_reg_o == $past(carry_out_o)));

endmodule

// File: tb/test_tern_chain_adder.sv
module test_tern_chain_adder;

    localparam int  W      = 20;
    localparam int  HW     = 10;
    localparam time PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a0, b0, c0, a1, b1, c1;
    logic         three_op;
    logic [1:0]   seg;
    logic         cin, shin;

    logic [W-1:0] sum_lo, sum_hi;
    logic         co_lo, co_hi, cr_lo, cr_hi, sh_lo, sh_hi;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    tern_chain_adder i_tern_chain_adder (
        .clk(clk), .rst(rst), .a_i(a0), .b_i(b0), .c_i(c0),
        .three_op_i(three_op), .seg_i(seg), .carry_in_i(cin), .shared_in_i(shin),
        .sum_q_o(sum_lo), .carry_out_o(co_lo), .cout_reg_o(cr_lo), .shared_out_o(sh_lo)
    );

    tern_chain_adder i_tern_chain_adder_hi (
        .clk(clk), .rst(rst), .a_i(a1), .b_i(b1), .c_i(c1),
        .three_op_i(three_op), .seg_i(seg), .carry_in_i(co_lo), .shared_in_i(sh_lo),
        .sum_q_o(sum_hi), .carry_out_o(co_hi), .cout_reg_o(cr_hi), .shared_out_o(sh_hi)
    );

    // behavioural model: returns {shared_out, carry_out, sum}
    function automatic logic [W+1:0] model(input logic [W-1:0] a, b, c,
                                           input logic three, input logic [1:0] sg,
                                           input logic ci, input logic si);
        int off, w, top;
        logic [63:0] m, tot, hi;
        logic        sh, co;
        logic [W-1:0] s;
        off = (sg == 2'b10) ? HW : 0;
        w   = (sg == 2'b01 || sg == 2'b10) ? HW : W;
        top = off + w - 1;
        m   = (64'd1 << w) - 64'd1;
        tot = ((64'(a) >> off) & m) + ((64'(b) >> off) & m) + 64'(ci);
        if (three) tot = tot + ((64'(c) >> off) & m) + 64'(si);
        s  = W'((tot & m) << off);
        hi = tot >> w;
        sh = three ? ((a[top] & b[top]) | (a[top] & c[top]) | (b[top] & c[top])) : 1'b0;
        co = 1'(hi - 64'(sh));
        return {sh, co, s};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string sum_tag(input logic three, input logic [1:0] sg);
        case (sg)
            2'b01:   return "R4";
            2'b10:   return "R5";
            2'b11:   return "R6";
            default: return three ? "R2" : "R1";
        endcase
    endfunction

    task automatic step(input logic [W-1:0] ia0, ib0, ic0, ia1, ib1, ic1,
                        input logic ith, input logic [1:0] isg,
                        input logic ici, input logic isi);
        logic [W+1:0] e_lo, e_hi;
        logic [63:0]  m, pa, pb, pc, tot, act;
        int off, w;
        a0 = ia0; b0 = ib0; c0 = ic0; a1 = ia1; b1 = ib1; c1 = ic1;
        three_op = ith; seg = isg; cin = ici; shin = isi;
        e_lo = model(ia0, ib0, ic0, ith, isg, ici, isi);
        e_hi = model(ia1, ib1, ic1, ith, isg, e_lo[W], e_lo[W+1]);
        #1;
        chk("R1/R4/R5 lo carry_out", 64'(co_lo), 64'(e_lo[W]));
        chk("R9 hi carry_out", 64'(co_hi), 64'(e_hi[W]));
        chk(ith ? "R10 lo shared_out" : "R3 lo shared_out", 64'(sh_lo), 64'(e_lo[W+1]));
        chk(ith ? "R10 hi shared_out" : "R3 hi shared_out", 64'(sh_hi), 64'(e_hi[W+1]));
        @(negedge clk);
        chk({sum_tag(ith, isg), " lo sum"}, 64'(sum_lo), 64'(e_lo[W-1:0]));
        chk("R9 hi sum", 64'(sum_hi), 64'(e_hi[W-1:0]));
        chk("R7 lo cout_reg", 64'(cr_lo), 64'(e_lo[W]));
        chk("R7 hi cout_reg", 64'(cr_hi), 64'(e_hi[W]));
        // R9: stacked pair against a plain integer sum of double width
        off = (isg == 2'b10) ? HW : 0;
        w   = (isg == 2'b01 || isg == 2'b10) ? HW : W;
        m   = (64'd1 << w) - 64'd1;
        pa  = (((64'(ia1) >> off) & m) << w) | ((64'(ia0) >> off) & m);
        pb  = (((64'(ib1) >> off) & m) << w) | ((64'(ib0) >> off) & m);
        pc  = (((64'(ic1) >> off) & m) << w) | ((64'(ic0) >> off) & m);
        tot = pa + pb + 64'(ici);
        if (ith) tot = tot + pc + 64'(isi);
        tot = tot & ((64'd1 << (2*w)) - 64'd1);
        act = (((64'(sum_hi) >> off) & m) << w) | ((64'(sum_lo) >> off) & m);
        chk("R9 stacked sum", act, tot);
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin
        #(PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [W-1:0] ONES = '1;

    initial begin
        rst = 1'b1;
        a0 = rnd(); b0 = rnd(); c0 = rnd(); a1 = rnd(); b1 = rnd(); c1 = rnd();
        three_op = 1'b1; seg = 2'b00; cin = 1'b1; shin = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset holds the registered outputs at zero
        chk("R8 lo sum", 64'(sum_lo), 64'd0);
        chk("R8 hi sum", 64'(sum_hi), 64'd0);
        chk("R8 lo cout_reg", 64'(cr_lo), 64'd0);
        chk("R8 hi cout_reg", 64'(cr_hi), 64'd0);
        rst = 1'b0;

        // R1: carry rippling through both slices
        step(ONES, '0, rnd(), ONES, '0, rnd(), 1'b0, 2'b00, 1'b1, 1'b1);
        // R2: three all-ones operands plus both chain inputs
        step(ONES, ONES, ONES, ONES, ONES, ONES, 1'b1, 2'b00, 1'b1, 1'b1);
        // R3: C and shared_in vary, two-operand result must not
        step(20'h12345, 20'h0F0F0, ONES, 20'h00001, 20'h00002, ONES, 1'b0, 2'b00, 1'b0, 1'b1);
        step(20'h12345, 20'h0F0F0, '0,   20'h00001, 20'h00002, '0,   1'b0, 2'b00, 1'b0, 1'b0);
        // R4: lower half saturates, upper operand bits full of noise
        step({10'h3A5, 10'h3FF}, {10'h1C3, 10'h000}, rnd(), {10'h2B1, 10'h3FF}, rnd(), rnd(),
             1'b0, 2'b01, 1'b1, 1'b0);
        // R5: upper half starts at cell 5 with the chain inputs
        step({10'h3FF, 10'h155}, {10'h000, 10'h2AA}, rnd(), {10'h3FF, 10'h0F0}, rnd(), rnd(),
             1'b0, 2'b10, 1'b1, 1'b0);
        step({10'h3FF, 10'h155}, {10'h3FF, 10'h2AA}, {10'h3FF, 10'h001}, rnd(), rnd(), rnd(),
             1'b1, 2'b10, 1'b1, 1'b1);
        // R6: alternate full encoding
        step(ONES, ONES, ONES, rnd(), rnd(), rnd(), 1'b1, 2'b11, 1'b0, 1'b1);

        // random sweep over every segment code and both modes (R1, R2, R4, R5, R6, R9, R10)
        for (int sg = 0; sg < 4; sg++) begin
            for (int th = 0; th < 2; th++) begin
                for (int n = 0; n < 40; n++) begin
                    step(rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), 1'(th), 2'(sg),
                         1'($urandom), 1'($urandom));
                end
            end
        end

        // R8: reset in the middle of traffic clears the registers again
        rst = 1'b1;
        a0 = ONES; b0 = ONES; cin = 1'b1;
        @(negedge clk);
        chk("R8 lo sum mid-run", 64'(sum_lo), 64'd0);
        chk("R8 lo cout_reg mid-run", 64'(cr_lo), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule